// File: doc/BRIEF.md
# PC Keyboard Controller Command Processor

This block is the host-facing command engine of a PC-style keyboard controller. The host writes bytes to a command port and a data port. Each command port byte is decoded in one clock cycle. A command can update the controller mode, status or output-port register. It can push a reply byte toward the keyboard-side or auxiliary-side output queue. It can also arm a latch so that the next data-port byte is redirected. A data-port byte with no armed latch is forwarded to the keyboard.

The output port drives the A20 gate line directly and can request a one-cycle system reset. The pulse-command group can request that reset as well. The receive-buffer-full and interrupt indications are formed from two inputs, one for each device, that report pending device data. The translation-enable flag is a mode bit brought out for the scan-code stage that sits outside this block.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After reset the mode register reads 0x03, status reads 0x18 (with no pending device data) and the output port reads 0x03. A20 is high. Translation enable, both interrupts, the reset request, every strobe and the error flag are low.
- R2: Command 0x20 pushes the current mode byte as a keyboard-side reply (resp_aux low).
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 produce no output and only arm the latch. The next data byte is routed by the latch, and then the latch is cleared, so the following data byte goes to the keyboard forward strobe.
- R4: A data byte after 0x60 becomes the mode register, and mode bit 6 drives xlate_en.
- R5: A data byte after 0xD2 is replied keyboard-side. After 0xD3 it is replied aux-side. After 0xD4 it pulses aux_tx_valid. With no latch it pulses kbd_tx_valid. In the forward cases tx_byte carries the byte.
- R6: 0xA7 and 0xA8 set and clear mode bit 5. 0xAD and 0xAE set and clear mode bit 4, which gates the keyboard interrupt at once.
- R7: 0xAA sets status bit 2 and replies 0x55. 0xA9, 0xAB and 0xC0 reply 0x00. 0xD0 replies the live output-port value.
- R8: 0xDF sets output-port bit 1 and raises a20_gate. 0xDD clears both.
- R9: A command with upper nibble 0xF requests a one-cycle cpu_reset_req when bit 0 is 0 and does nothing when bit 0 is 1.
- R10: A data byte after 0xD1 is stored as the output port. a20_gate follows its bit 1, and a reset is requested when its bit 0 is 0.
- R11: Status bit 0 and output-port bit 4 show that any device data is pending. Status bit 5 and output-port bit 5 show that only aux data is pending. irq_kbd = keyboard pending, mode bit 0 set and mode bit 4 clear. irq_aux = aux-only pending and mode bit 1 set.
- R12: A command code not listed above changes no register and produces no output. It sets bad_cmd, which stays high until reset.
- R13: When cmd_we and data_we are high in the same cycle, the command is served. The data byte has no effect and leaves the latch as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command port write strobe |
| data_we | input | 1 | Data port write strobe |
| wr_byte | input | 8 | Written byte |
| kbd_pend | input | 1 | Keyboard device has data pending |
| aux_pend | input | 1 | Auxiliary device has data pending |
| resp_valid | output | 1 | One-cycle reply push |
| resp_aux | output | 1 | Reply goes to the auxiliary queue |
| resp_byte | output | 8 | Reply byte |
| kbd_tx_valid | output | 1 | One-cycle forward to keyboard |
| aux_tx_valid | output | 1 | One-cycle forward to auxiliary device |
| tx_byte | output | 8 | Forwarded byte |
| mode_reg | output | 8 | Mode register |
| status_reg | output | 8 | Status register with live pending bits |
| outport_reg | output | 8 | Output port with live pending bits |
| a20_gate | output | 1 | A20 gate line |
| cpu_reset_req | output | 1 | One-cycle system reset request |
| xlate_en | output | 1 | Scan-code translation enable |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |
| bad_cmd | output | 1 | Sticky unknown-command flag |

## Verification
A command write and a data write can land in the same cycle, and so can an armed latch and a fresh command. The bench arms the 0xD2 latch. It then raises both strobes together, with command 0x20 and a data byte. It expects exactly the mode reply and no forward strobe. Next it sends one lone data byte, which must be replied keyboard-side. That shows the latch survived and the colliding data byte was dropped.

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine #(
  parameter logic [7:0] MODE_RST  = 8'h03,
  parameter logic [7:0] STAT_RST  = 8'h18,
  parameter logic [7:0] OUTP_RST  = 8'h03,
  parameter logic [7:0] TEST_PASS = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic       data_we,
  input  logic [7:0] wr_byte,
  input  logic       kbd_pend,
  input  logic       aux_pend,
  output logic       resp_valid,
  output logic       resp_aux,
  output logic [7:0] resp_byte,
  output logic       kbd_tx_valid,
  output logic       aux_tx_valid,
  output logic [7:0] tx_byte,
  output logic [7:0] mode_reg,
  output logic [7:0] status_reg,
  output logic [7:0] outport_reg,
  output logic       a20_gate,
  output logic       cpu_reset_req,
  output logic       xlate_en,
  output logic       irq_kbd,
  output logic       irq_aux,
  output logic       bad_cmd
);

  logic [7:0] mode_q, stat_q, outp_q, latch_q;
  logic [7:0] mode_n, stat_n, outp_n, latch_n;
  logic       rv_n, ra_n, ktx_n, atx_n, rst_req_n, bad_n;
  logic [7:0] rb_n, txb_n;

  wire any_pend = kbd_pend | aux_pend;
  wire aux_only = aux_pend & ~kbd_pend;

  assign status_reg  = {stat_q[7:6], aux_only, stat_q[4:1], any_pend};
  assign outport_reg = {outp_q[7:6], aux_only, any_pend, outp_q[3:0]};
  assign mode_reg    = mode_q;
  assign a20_gate    = outp_q[1];
  assign xlate_en    = mode_q[6];
  assign irq_kbd     = kbd_pend & mode_q[0] & ~mode_q[4];
  assign irq_aux     = aux_only & mode_q[1];

  always_comb begin
    mode_n    = mode_q;
    stat_n    = stat_q;
    outp_n    = outp_q;
    latch_n   = latch_q;
    bad_n     = bad_cmd;
    rv_n      = 1'b0;
    ra_n      = 1'b0;
    rb_n      = 8'h00;
    ktx_n     = 1'b0;
    atx_n     = 1'b0;
    txb_n     = 8'h00;
    rst_req_n = 1'b0;
    if (cmd_we) begin
      if (wr_byte[7:4] == 4'hF) begin
        rst_req_n = ~wr_byte[0];
      end else begin
        case (wr_byte)
          8'h20: begin rv_n = 1'b1; rb_n = mode_q; end
          8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4: latch_n = wr_byte;
          8'hA7: mode_n[5] = 1'b1;
          8'hA8: mode_n[5] = 1'b0;
          8'hAD: mode_n[4] = 1'b1;
          8'hAE: mode_n[4] = 1'b0;
          8'hAA: begin stat_n[2] = 1'b1; rv_n = 1'b1; rb_n = TEST_PASS; end
          8'hA9, 8'hAB, 8'hC0: begin rv_n = 1'b1; rb_n = 8'h00; end
          8'hD0: begin rv_n = 1'b1; rb_n = outport_reg; end
          8'hDF: outp_n[1] = 1'b1;
          8'hDD: outp_n[1] = 1'b0;
          default: bad_n = 1'b1;
        endcase
      end
    end else if (data_we) begin
      latch_n = 8'h00;
      case (latch_q)
        8'h60: mode_n = wr_byte;
        8'hD1: begin outp_n = wr_byte; rst_req_n = ~wr_byte[0]; end
        8'hD2: begin rv_n = 1'b1; rb_n = wr_byte; end
        8'hD3: begin rv_n = 1'b1; ra_n = 1'b1; rb_n = wr_byte; end
        8'hD4: begin atx_n = 1'b1; txb_n = wr_byte; end
        default: begin ktx_n = 1'b1; txb_n = wr_byte; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q        <= MODE_RST;
      stat_q        <= STAT_RST;
      outp_q        <= OUTP_RST;
      latch_q       <= 8'h00;
      bad_cmd       <= 1'b0;
      resp_valid    <= 1'b0;
      resp_aux      <= 1'b0;
      resp_byte     <= 8'h00;
      kbd_tx_valid  <= 1'b0;
      aux_tx_valid  <= 1'b0;
      tx_byte       <= 8'h00;
      cpu_reset_req <= 1'b0;
    end else begin
      mode_q        <= mode_n;
      stat_q        <= stat_n;
      outp_q        <= outp_n;
      latch_q       <= latch_n;
      bad_cmd       <= bad_n;
      resp_valid    <= rv_n;
      resp_aux      <= ra_n;
      resp_byte     <= rb_n;
      kbd_tx_valid  <= ktx_n;
      aux_tx_valid  <= atx_n;
      tx_byte       <= txb_n;
      cpu_reset_req <= rst_req_n;
    end
  end

endmodule

// File: rtl/kbc_cmd_engine_chk.sv
module kbc_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic       data_we,
  input logic [7:0] wr_byte,
  input logic       resp_valid,
  input logic       kbd_tx_valid,
  input logic       aux_tx_valid,
  input logic       a20_gate,
  input logic       cpu_reset_req,
  input logic       irq_kbd,
  input logic       irq_aux,
  input logic       bad_cmd
);

  a_r3_latch_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && wr_byte == 8'h60) |=> !resp_valid && !kbd_tx_valid && !aux_tx_valid);

  a_r8_a20_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && wr_byte == 8'hDF) |=> a20_gate);

  a_r9_reset_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset_req |-> ($past(cmd_we) || $past(data_we)));

  a_r11_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_kbd && irq_aux));

  a_r12_bad_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |=> bad_cmd);

  a_r13_collision_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && data_we) |=> !kbd_tx_valid && !aux_tx_valid);

endmodule

bind kbc_cmd_engine kbc_cmd_engine_chk u_chk (.*);

// File: tb/tb_kbc_cmd_engine.sv
`timescale 1ns/1ps
module tb_kbc_cmd_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0, data_we = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic kbd_pend = 1'b0, aux_pend = 1'b0;
  logic resp_valid, resp_aux, kbd_tx_valid, aux_tx_valid;
  logic [7:0] resp_byte, tx_byte, mode_reg, status_reg, outport_reg;
  logic a20_gate, cpu_reset_req, xlate_en, irq_kbd, irq_aux, bad_cmd;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  kbc_cmd_engine dut (.*);

  // {tag[4], cmd, byte, rv, raux, rbyte, ktx, atx, mode}
  localparam int NV = 25;
  localparam logic [32:0] VEC [NV] = '{
    {4'd2,  1'b1, 8'h20, 1'b1, 1'b0, 8'h03, 1'b0, 1'b0, 8'h03}, // R2
    {4'd3,  1'b1, 8'h60, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h03}, // R3
    {4'd4,  1'b0, 8'h47, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h47}, // R4
    {4'd2,  1'b1, 8'h20, 1'b1, 1'b0, 8'h47, 1'b0, 1'b0, 8'h47},
    {4'd6,  1'b1, 8'hA7, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h67}, // R6
    {4'd6,  1'b1, 8'hA8, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h47},
    {4'd6,  1'b1, 8'hAD, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h57},
    {4'd6,  1'b1, 8'hAE, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h47},
    {4'd3,  1'b1, 8'hD2, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h47},
    {4'd5,  1'b0, 8'h5A, 1'b1, 1'b0, 8'h5A, 1'b0, 1'b0, 8'h47}, // R5
    {4'd3,  1'b1, 8'hD3, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h47},
    {4'd5,  1'b0, 8'h3C, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0, 8'h47},
    {4'd3,  1'b1, 8'hD4, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h47},
    {4'd5,  1'b0, 8'hE6, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h47},
    {4'd3,  1'b0, 8'hED, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h47},
    {4'd7,  1'b1, 8'hA9, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h47}, // R7
    {4'd7,  1'b1, 8'hAB, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h47},
    {4'd7,  1'b1, 8'hC0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h47},
    {4'd7,  1'b1, 8'hAA, 1'b1, 1'b0, 8'h55, 1'b0, 1'b0, 8'h47},
    {4'd7,  1'b1, 8'hD0, 1'b1, 1'b0, 8'h03, 1'b0, 1'b0, 8'h47},
    {4'd8,  1'b1, 8'hDD, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h47}, // R8
    {4'd8,  1'b1, 8'hD0, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 8'h47},
    {4'd8,  1'b1, 8'hDF, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h47},
    {4'd8,  1'b1, 8'hD0, 1'b1, 1'b0, 8'h03, 1'b0, 1'b0, 8'h47},
    {4'd9,  1'b1, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h47}  // R9
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic [7:0] b);
    @(negedge clk);
    cmd_we = c; data_we = !c; wr_byte = b;
    @(negedge clk);
    cmd_we = 1'b0; data_we = 1'b0;
  endtask

  task automatic reset_state_check(input string tag);
    logic [31:0] act;
    act = {mode_reg, status_reg, outport_reg, a20_gate, xlate_en, irq_kbd, irq_aux,
           cpu_reset_req, bad_cmd, resp_valid, kbd_tx_valid|aux_tx_valid};
    chk(act == {8'h03, 8'h18, 8'h03, 8'b1000_0000}, tag, act, {8'h03, 8'h18, 8'h03, 8'h80});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reset_state_check("R1 reset values");

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      logic [19:0] act, exp;
      bit txok;
      v = VEC[i];
      wr(v[28], v[27:20]);
      exp = {v[19:18], v[17:10], v[9:8], v[7:0]};
      act = {resp_valid, resp_aux, resp_valid ? resp_byte : 8'h00, kbd_tx_valid, aux_tx_valid, mode_reg};
      txok = !(kbd_tx_valid | aux_tx_valid) || (tx_byte == v[27:20]);
      checks++;
      if (act != exp || !txok || cpu_reset_req) begin
        fails++;
        $display("FAIL R%0d table vector %0d: actual %h/%h/%b expected %h/%h/0",
                 v[32:29], i, act, tx_byte, cpu_reset_req, exp, v[27:20]);
      end
    end

    chk(status_reg == 8'h1C, "R7 self-test status bit", status_reg, 8'h1C);
    chk(xlate_en == 1'b1, "R4 translation enable", xlate_en, 1);

    // R9 pulse commands
    wr(1'b1, 8'hFE);
    chk(cpu_reset_req == 1'b1, "R9 even pulse requests reset", cpu_reset_req, 1);
    @(negedge clk);
    chk(cpu_reset_req == 1'b0, "R9 reset pulse one cycle", cpu_reset_req, 0);
    wr(1'b1, 8'hF1);
    chk(cpu_reset_req == 1'b0 && !bad_cmd, "R9 odd pulse no-op", {bad_cmd, cpu_reset_req}, 0);
    wr(1'b1, 8'hF4);
    chk(cpu_reset_req == 1'b1, "R9 F4 requests reset", cpu_reset_req, 1);

    // R10 output port write
    wr(1'b1, 8'hD1);
    wr(1'b0, 8'h00);
    chk({outport_reg, a20_gate, cpu_reset_req} == {8'h00, 1'b0, 1'b1}, "R10 outport 00",
        {outport_reg, a20_gate, cpu_reset_req}, {8'h00, 2'b01});
    wr(1'b1, 8'hD1);
    wr(1'b0, 8'h03);
    chk({outport_reg, a20_gate, cpu_reset_req} == {8'h03, 1'b1, 1'b0}, "R10 outport 03",
        {outport_reg, a20_gate, cpu_reset_req}, {8'h03, 2'b10});

    // R11 pending and interrupts
    @(negedge clk); kbd_pend = 1'b1; #1;
    chk({status_reg, irq_kbd, irq_aux} == {8'h1D, 2'b10}, "R11 keyboard pending",
        {status_reg, irq_kbd, irq_aux}, {8'h1D, 2'b10});
    wr(1'b1, 8'hAD);
    chk(irq_kbd == 1'b0, "R6 disable gates keyboard irq", irq_kbd, 0);
    wr(1'b1, 8'hAE);
    chk(irq_kbd == 1'b1, "R6 enable restores keyboard irq", irq_kbd, 1);
    @(negedge clk); aux_pend = 1'b1; #1;
    chk({status_reg, irq_kbd, irq_aux} == {8'h1D, 2'b10}, "R11 keyboard has priority",
        {status_reg, irq_kbd, irq_aux}, {8'h1D, 2'b10});
    @(negedge clk); kbd_pend = 1'b0; #1;
    chk({status_reg, irq_kbd, irq_aux} == {8'h3D, 2'b01}, "R11 aux only",
        {status_reg, irq_kbd, irq_aux}, {8'h3D, 2'b01});
    wr(1'b1, 8'hD0);
    chk(resp_valid && resp_byte == 8'h33, "R11 outport pending bits", resp_byte, 8'h33);
    @(negedge clk); aux_pend = 1'b0;

    // R12 unknown command
    wr(1'b1, 8'h55);
    chk({resp_valid, mode_reg, outport_reg, bad_cmd} == {1'b0, 8'h47, 8'h03, 1'b1},
        "R12 unknown command", {resp_valid, mode_reg, outport_reg, bad_cmd}, {1'b0, 8'h47, 8'h03, 1'b1});
    wr(1'b1, 8'h20);
    chk(bad_cmd == 1'b1, "R12 error flag sticky", bad_cmd, 1);

    // R13 collision
    wr(1'b1, 8'hD2);
    @(negedge clk);
    cmd_we = 1'b1; data_we = 1'b1; wr_byte = 8'h20;
    @(negedge clk);
    cmd_we = 1'b0; data_we = 1'b0;
    chk({resp_valid, resp_byte, kbd_tx_valid, aux_tx_valid} == {1'b1, 8'h47, 2'b00},
        "R13 command served on collision", {resp_valid, resp_byte, kbd_tx_valid, aux_tx_valid}, {1'b1, 8'h47, 2'b00});
    wr(1'b0, 8'h11);
    chk({resp_valid, resp_aux, resp_byte} == {2'b10, 8'h11}, "R13 latch kept after collision",
        {resp_valid, resp_aux, resp_byte}, {2'b10, 8'h11});

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    reset_state_check("R1 reset after activity");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule